// File: doc/BRIEF.md
# SPI Serial Memory Command Engine

This block is the slave-side command front end for a byte-addressed serial memory of 32768 bytes. A host selects it with an active-low chip select and clocks commands in on SI, most significant bit first. The engine decodes an 8-bit opcode, gathers a 16-bit address where the command needs one, streams array or status bytes back on a tri-stated SO, and forwards write traffic to a page-write unit and a status/protection unit. Both SPI mode 0 (clock idles low) and mode 3 (clock idles high) are handled. Incoming bits are sampled on rising SCK and outgoing bits change on falling SCK.

All serial pins are asynchronous to the system clock. Each pin passes through a two-flop synchroniser, and SCK edges are found in the system clock domain. The SCK rate must therefore stay well below the system clock rate. The array is read through a combinational address/data port. Completed write bytes leave as single-cycle pulses, and the busy flag of the external write unit is an input. A pause input freezes a transfer in the middle of a byte without losing its place.

Top module: `spi_mem_cmd_engine`

## Requirements
- R1: The opcode is the first byte after select. Its upper nibble must be 0000 and bit 3 is ignored. The low three bits select the command: 110 set write latch, 100 clear write latch, 101 status read, 001 status write, 011 array read, 010 array write.
- R2: While chip select is high, so_oe is 0 and SCK and SI activity changes nothing. Every new select starts with so_oe at 0.
- R3: After an opcode that is not in R1, so_oe stays 0 and no write pulse is produced until chip select falls again.
- R4: An array read takes two address bytes, high byte first. Address bits 15 and above are ignored. The data byte at the address then shifts out MSB first, and the address increments after each byte, wrapping from 0x7FFF to 0x0000, for as long as select stays low.
- R5: A status read streams the byte {guard_bits[5:0], write latch, wr_busy}. The write latch is bit 1 and busy is bit 0.
- R6: The write latch is 0 after reset. The set-latch command sets it and the clear-latch command clears it.
- R7: An array write or status write received while the write latch is 0 produces no wr_byte_vld, wr_commit or sr_wr_vld pulse.
- R8: In an accepted array write, each complete data byte gives one wr_byte_vld pulse carrying its address and data. Only the low 6 address bits advance, wrapping inside a 64-byte page. The chip-select rise then gives one wr_commit pulse and clears the write latch.
- R9: In an accepted status write, the chip-select rise after a complete data byte gives one sr_wr_vld pulse with that byte, and the write latch clears.
- R10: While wr_busy is 1, every opcode other than status read is ignored.
- R11: When hold_n falls while SCK is low, the transfer pauses: so_oe is 0 and SCK edges are ignored. When hold_n rises while SCK is low, the transfer resumes at the same bit.
- R12: Mode 0 and mode 3 transfers produce identical results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock from host |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Active-low pause |
| so_d | output | 1 | Serial data out value |
| so_oe | output | 1 | Serial data out enable (tri-state control) |
| mem_addr | output | 15 | Array read address |
| mem_rdata | input | 8 | Array read data for mem_addr |
| guard_bits | input | 6 | Upper status bits from protection unit |
| wr_busy | input | 1 | Write cycle in progress |
| wr_byte_vld | output | 1 | One-cycle pulse: write byte ready |
| wr_byte_addr | output | 15 | Address of the write byte |
| wr_byte_data | output | 8 | Data of the write byte |
| wr_commit | output | 1 | One-cycle pulse: start page programming |
| sr_wr_vld | output | 1 | One-cycle pulse: status write |
| sr_wr_data | output | 8 | Status write byte |

## Verification
The bench targets the address wrap from 0x7FFF to 0 and the page wrap from 0x13F back to 0x100. A design that carried the page increment into bit 6 would report 0x140. Opcodes with bit 3 set, and opcodes with a nonzero upper nibble, expose decoders that compare the wrong bits: either a valid command goes dead or an invalid one drives SO. Writes attempted with the latch clear, and set-latch commands sent while busy, catch a latch that updates when it should not. A pause inserted mid-byte, with SCK still toggling, catches edge gating that loses or adds a bit, which shows up as a shifted read byte.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_CMD,
        ST_ADDR,
        ST_RDATA,
        ST_WDATA,
        ST_RDSR,
        ST_SRDATA,
        ST_IGN
    } seq_st_t;

    typedef enum logic [2:0] {
        K_NONE,
        K_WREN,
        K_WRDI,
        K_RDSR,
        K_WRSR,
        K_READ,
        K_WRITE
    } op_kind_t;

    typedef struct packed {
        logic sck;
        logic cs_n;
        logic si;
        logic hold_n;
    } pins_t;

    // Upper nibble must be zero; bit 3 is a don't-care.
    function automatic op_kind_t decode_op(input logic [7:0] b);
        op_kind_t k;
        k = K_NONE;
        if (b[7:4] == 4'b0000) begin
            case (b[2:0])
                3'b110:  k = K_WREN;
                3'b100:  k = K_WRDI;
                3'b101:  k = K_RDSR;
                3'b001:  k = K_WRSR;
                3'b011:  k = K_READ;
                3'b010:  k = K_WRITE;
                default: k = K_NONE;
            endcase
        end
        return k;
    endfunction

endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
    parameter int               W       = 4,
    parameter int               STAGES  = 2,
    parameter logic [W-1:0]     RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/spi_hold_ctl.sv
module spi_hold_ctl (
    input  logic clk,
    input  logic rst,
    input  logic cs_act,
    input  logic sck_s,
    input  logic hold_n_s,
    output logic hold_q
);
    logic hold_n_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_n_d <= 1'b1;
            hold_q   <= 1'b0;
        end else begin
            hold_n_d <= hold_n_s;
            if (!cs_act)
                hold_q <= 1'b0;
            else if (!sck_s && hold_n_d && !hold_n_s)
                hold_q <= 1'b1;
            else if (!sck_s && !hold_n_d && hold_n_s)
                hold_q <= 1'b0;
        end
    end
endmodule

// File: rtl/spi_cmd_fsm.sv
module spi_cmd_fsm
    import spi_cmd_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int PAGE_W = 6,
    parameter int GUARD_W = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cs_act,
    input  logic                cs_fall,
    input  logic                cs_rise,
    input  logic                sck_rise,
    input  logic                sck_fall,
    input  logic                si_s,
    input  logic                busy,
    input  logic [GUARD_W-1:0]  guard,
    input  logic [BYTE_W-1:0]   mem_rdata,
    output logic [ADDR_W-1:0]   addr_q,
    output logic                out_bit,
    output logic                out_vld,
    output logic                wel_q,
    output logic [2:0]          bit_pos,
    output logic                wr_byte_vld,
    output logic [ADDR_W-1:0]   wr_byte_addr,
    output logic [BYTE_W-1:0]   wr_byte_data,
    output logic                wr_commit,
    output logic                sr_wr_vld,
    output logic [BYTE_W-1:0]   sr_wr_data
);
    seq_st_t             st;
    logic [BYTE_W-1:0]   in_sr, out_sr, rx_byte, stat_byte;
    logic                addr_lo_next, is_rd, pend_wr, pend_sr;
    op_kind_t            kind;

    assign rx_byte   = {in_sr[BYTE_W-2:0], si_s};
    assign kind      = decode_op(rx_byte);
    assign stat_byte = {guard, wel_q, busy};
    assign out_bit   = out_sr[BYTE_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= ST_CMD; in_sr <= '0; out_sr <= '0; bit_pos <= '0;
            addr_q <= '0; addr_lo_next <= 1'b0; is_rd <= 1'b0;
            pend_wr <= 1'b0; pend_sr <= 1'b0; wel_q <= 1'b0; out_vld <= 1'b0;
            wr_byte_vld <= 1'b0; wr_byte_addr <= '0; wr_byte_data <= '0;
            wr_commit <= 1'b0; sr_wr_vld <= 1'b0; sr_wr_data <= '0;
        end else begin
            wr_byte_vld <= 1'b0;
            wr_commit   <= 1'b0;
            sr_wr_vld   <= 1'b0;
            if (cs_rise || cs_fall) begin
                if (cs_rise && pend_wr) begin wr_commit <= 1'b1; wel_q <= 1'b0; end
                if (cs_rise && pend_sr) begin sr_wr_vld <= 1'b1; wel_q <= 1'b0; end
                pend_wr <= 1'b0; pend_sr <= 1'b0;
                st <= ST_CMD; bit_pos <= '0; out_vld <= 1'b0; addr_lo_next <= 1'b0;
            end else if (cs_act && sck_rise) begin
                in_sr   <= rx_byte;
                bit_pos <= bit_pos + 3'd1;
                if (bit_pos == 3'd7) begin
                    case (st)
                        ST_CMD: begin
                            if (busy && kind != K_RDSR) st <= ST_IGN;
                            else begin
                                case (kind)
                                    K_WREN:  begin wel_q <= 1'b1; st <= ST_IGN; end
                                    K_WRDI:  begin wel_q <= 1'b0; st <= ST_IGN; end
                                    K_RDSR:  st <= ST_RDSR;
                                    K_WRSR:  st <= wel_q ? ST_SRDATA : ST_IGN;
                                    K_READ:  begin st <= ST_ADDR; is_rd <= 1'b1; end
                                    K_WRITE: begin
                                        st <= wel_q ? ST_ADDR : ST_IGN; is_rd <= 1'b0;
                                    end
                                    default: st <= ST_IGN;
                                endcase
                            end
                        end
                        ST_ADDR: begin
                            if (!addr_lo_next) begin
                                addr_q[ADDR_W-1:BYTE_W] <= rx_byte[ADDR_W-BYTE_W-1:0];
                                addr_lo_next <= 1'b1;
                            end else begin
                                addr_q[BYTE_W-1:0] <= rx_byte;
                                st <= is_rd ? ST_RDATA : ST_WDATA;
                            end
                        end
                        ST_WDATA: begin
                            wr_byte_vld  <= 1'b1;
                            wr_byte_addr <= addr_q;
                            wr_byte_data <= rx_byte;
                            addr_q[PAGE_W-1:0] <= addr_q[PAGE_W-1:0] + 1'b1;
                            pend_wr <= 1'b1;
                        end
                        ST_SRDATA: begin
                            sr_wr_data <= rx_byte;
                            pend_sr    <= 1'b1;
                            st         <= ST_IGN;
                        end
                        default: ;
                    endcase
                end
            end else if (cs_act && sck_fall && (st == ST_RDATA || st == ST_RDSR)) begin
                if (bit_pos == 3'd0) begin
                    out_vld <= 1'b1;
                    if (st == ST_RDATA) begin
                        out_sr <= mem_rdata;
                        addr_q <= addr_q + 1'b1;
                    end else begin
                        out_sr <= stat_byte;
                    end
                end else begin
                    out_sr <= {out_sr[BYTE_W-2:0], 1'b0};
                end
            end
        end
    end
endmodule

// File: rtl/spi_mem_cmd_engine.sv
module spi_mem_cmd_engine
    import spi_cmd_pkg::*;
#(
    parameter int ADDR_W  = 15,
    parameter int PAGE_W  = 6,
    parameter int GUARD_W = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sck,
    input  logic               cs_n,
    input  logic               si,
    input  logic               hold_n,
    output logic               so_d,
    output logic               so_oe,
    output logic [ADDR_W-1:0]  mem_addr,
    input  logic [BYTE_W-1:0]  mem_rdata,
    input  logic [GUARD_W-1:0] guard_bits,
    input  logic               wr_busy,
    output logic               wr_byte_vld,
    output logic [ADDR_W-1:0]  wr_byte_addr,
    output logic [BYTE_W-1:0]  wr_byte_data,
    output logic               wr_commit,
    output logic               sr_wr_vld,
    output logic [BYTE_W-1:0]  sr_wr_data
);
    localparam int PIN_W = $bits(pins_t);

    pins_t raw, syn;
    logic  sck_d, cs_act, cs_act_d, cs_fall, cs_rise;
    logic  hold_q, sck_rise, sck_fall, out_vld, out_bit, wel_q;
    logic [2:0] bit_pos;

    assign raw = '{sck: sck, cs_n: cs_n, si: si, hold_n: hold_n};

    spi_in_sync #(.W(PIN_W), .STAGES(2), .RST_VAL(PIN_W'(4'b0101))) u_sync (
        .clk(clk), .rst(rst), .d(raw), .q(syn)
    );

    assign cs_act = !syn.cs_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_d    <= 1'b0;
            cs_act_d <= 1'b0;
        end else begin
            sck_d    <= syn.sck;
            cs_act_d <= cs_act;
        end
    end

    assign cs_fall  = cs_act && !cs_act_d;
    assign cs_rise  = !cs_act && cs_act_d;

    spi_hold_ctl u_hold (
        .clk(clk), .rst(rst), .cs_act(cs_act), .sck_s(syn.sck),
        .hold_n_s(syn.hold_n), .hold_q(hold_q)
    );

    assign sck_rise = syn.sck && !sck_d && !hold_q;
    assign sck_fall = !syn.sck && sck_d && !hold_q;

    spi_cmd_fsm #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .GUARD_W(GUARD_W)) u_fsm (
        .clk(clk), .rst(rst), .cs_act(cs_act), .cs_fall(cs_fall), .cs_rise(cs_rise),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .si_s(syn.si), .busy(wr_busy),
        .guard(guard_bits), .mem_rdata(mem_rdata), .addr_q(mem_addr),
        .out_bit(out_bit), .out_vld(out_vld), .wel_q(wel_q), .bit_pos(bit_pos),
        .wr_byte_vld(wr_byte_vld), .wr_byte_addr(wr_byte_addr),
        .wr_byte_data(wr_byte_data), .wr_commit(wr_commit),
        .sr_wr_vld(sr_wr_vld), .sr_wr_data(sr_wr_data)
    );

    assign so_d  = out_bit;
    assign so_oe = out_vld && cs_act && !hold_q;
endmodule

// File: rtl/spi_cmd_checker.sv
module spi_cmd_checker (
    input logic       clk,
    input logic       rst,
    input logic       cs_fall,
    input logic       so_oe,
    input logic       hold_q,
    input logic [2:0] bit_pos,
    input logic       wel_q,
    input logic       wr_byte_vld,
    input logic       wr_commit,
    input logic       sr_wr_vld
);
    // R2
    sel_start_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        cs_fall |=> !so_oe);

    // R11
    hold_keeps_pos_chk: assert property (@(posedge clk) disable iff (rst)
        (hold_q && $past(hold_q)) |-> $stable(bit_pos));

    // R8
    commit_clears_wel_chk: assert property (@(posedge clk) disable iff (rst)
        wr_commit |=> !wel_q);

    // R9
    sr_needs_wel_chk: assert property (@(posedge clk) disable iff (rst)
        sr_wr_vld |-> $past(wel_q));

    // R7
    byte_needs_wel_chk: assert property (@(posedge clk) disable iff (rst)
        wr_byte_vld |-> wel_q);

    // R8
    one_event_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wr_byte_vld, wr_commit, sr_wr_vld}));
endmodule

bind spi_mem_cmd_engine spi_cmd_checker u_chk (
    .clk(clk), .rst(rst), .cs_fall(cs_fall), .so_oe(so_oe), .hold_q(hold_q),
    .bit_pos(bit_pos), .wel_q(wel_q), .wr_byte_vld(wr_byte_vld),
    .wr_commit(wr_commit), .sr_wr_vld(sr_wr_vld)
);

// File: tb/test_spi_mem_cmd_engine.sv
`timescale 1ns/1ps
module test_spi_mem_cmd_engine;
    localparam int H = 8;
    localparam logic [5:0] GUARD = 6'h2A;

    logic clk = 1'b0, rst = 1'b1;
    logic sck = 1'b0, cs_n = 1'b1, si = 1'b0, hold_n = 1'b1;
    logic so_d, so_oe, wr_busy = 1'b0;
    logic [14:0] mem_addr, wr_byte_addr;
    logic [7:0]  mem_rdata, wr_byte_data, sr_wr_data;
    logic wr_byte_vld, wr_commit, sr_wr_vld;

    int n_cmp = 0, n_bad = 0, commit_cnt = 0, sr_cnt = 0, hi_run = 0;
    bit finished = 0;
    logic [7:0]  sr_last = '0;
    logic [14:0] wq_addr[$];
    logic [7:0]  wq_data[$];

    always #2.5 clk = ~clk;

    function automatic logic [7:0] fmem(input logic [14:0] a);
        return a[7:0] ^ {1'b0, a[14:8]} ^ 8'hA5;
    endfunction
    assign mem_rdata = fmem(mem_addr);

    spi_mem_cmd_engine i_spi_mem_cmd_engine (
        .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .si(si), .hold_n(hold_n),
        .so_d(so_d), .so_oe(so_oe), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .guard_bits(GUARD), .wr_busy(wr_busy), .wr_byte_vld(wr_byte_vld),
        .wr_byte_addr(wr_byte_addr), .wr_byte_data(wr_byte_data),
        .wr_commit(wr_commit), .sr_wr_vld(sr_wr_vld), .sr_wr_data(sr_wr_data)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Per-clock model: deselected for a while means SO floats (R2).
    always @(negedge clk) begin
        if (!rst) begin
            hi_run = cs_n ? hi_run + 1 : 0;
            if (hi_run > 6) chk(!so_oe, "R2 so_oe while deselected", so_oe, 0);
            if (wr_byte_vld) begin wq_addr.push_back(wr_byte_addr); wq_data.push_back(wr_byte_data); end
            if (wr_commit) commit_cnt++;
            if (sr_wr_vld) begin sr_cnt++; sr_last = sr_wr_data; end
        end
    end

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sel(input bit m3);
        sck = m3; wait_clks(H); cs_n = 1'b0; wait_clks(H);
    endtask

    task automatic desel(input bit m3);
        if (!m3) sck = 1'b0;
        wait_clks(H); cs_n = 1'b1; wait_clks(3*H);
    endtask

    task automatic xfer(input logic [7:0] tx, input int hold_at,
                        output logic [7:0] rx, output bit oe_seen);
        rx = '0; oe_seen = 0;
        for (int k = 7; k >= 0; k--) begin
            sck = 1'b0; wait_clks(H);
            if (k == hold_at) begin
                hold_n = 1'b0; wait_clks(6);
                chk(!so_oe, "R11 so_oe during pause", so_oe, 0);
                for (int t = 0; t < 3; t++) begin
                    sck = 1'b1; wait_clks(H); sck = 1'b0; wait_clks(H);
                end
                chk(!so_oe, "R11 so_oe after toggles", so_oe, 0);
                hold_n = 1'b1; wait_clks(6);
            end
            si = tx[k]; wait_clks(H);
            rx[k] = so_d;
            if (so_oe) oe_seen = 1;
            sck = 1'b1; wait_clks(H);
        end
    endtask

    task automatic send(input logic [7:0] b);
        logic [7:0] r; bit o;
        xfer(b, -1, r, o);
    endtask

    task automatic one_op(input logic [7:0] op, input bit m3);
        sel(m3); send(op); desel(m3);
    endtask

    task automatic rdsr(input logic [7:0] exp, input string tag, input bit m3);
        logic [7:0] r; bit o;
        sel(m3); send(8'h05);
        xfer(8'h00, -1, r, o);
        chk(o && r == exp, tag, r, exp);
        xfer(8'h00, -1, r, o);
        chk(r == exp, {tag, " repeat"}, r, exp);
        desel(m3);
    endtask

    task automatic rd(input logic [7:0] op, input logic [15:0] a, input int n,
                      input bit m3, input int hold_at, input string tag);
        logic [7:0] r; bit o;
        logic [14:0] ea;
        ea = a[14:0];
        sel(m3); send(op); send(a[15:8]); send(a[7:0]);
        for (int i = 0; i < n; i++) begin
            xfer(8'h00, (i == 1) ? hold_at : -1, r, o);
            chk(o && r == fmem(ea), tag, r, fmem(ea));
            ea = ea + 15'd1;
        end
        desel(m3);
    endtask

    initial begin
        logic [7:0] r; bit o;
        int c0;
        wait_clks(10); rst = 1'b0; wait_clks(10);

        chk(!so_oe && !wr_byte_vld && !wr_commit && !sr_wr_vld, "R2 reset outputs", so_oe, 0);
        // R6 latch clear after reset; R5 layout {guard, wel, busy}
        rdsr({GUARD, 2'b00}, "R6 R5 status after reset", 0);
        one_op(8'h06, 0);
        rdsr({GUARD, 2'b10}, "R6 set latch", 0);
        one_op(8'h0C, 1);
        rdsr({GUARD, 2'b00}, "R1 R6 clear latch bit3 set", 1);
        one_op(8'h0E, 0);
        rdsr({GUARD, 2'b10}, "R1 set latch bit3 set", 1);
        one_op(8'h04, 0);
        rdsr({GUARD, 2'b00}, "R6 clear latch", 0);

        // R4 reads, R12 both modes
        rd(8'h03, 16'h1234, 3, 0, -1, "R4 read mode0");
        rd(8'h03, 16'h9234, 2, 1, -1, "R4 R12 top bit ignored mode3");
        rd(8'h0B, 16'h7FFE, 3, 1, -1, "R4 R1 wrap to zero");

        // R3 invalid opcodes
        sel(0); send(8'h85);
        xfer(8'h00, -1, r, o); chk(!o, "R3 upper nibble opcode", o, 0);
        xfer(8'h03, -1, r, o); chk(!o, "R3 ignored bytes", o, 0);
        desel(0);
        one_op(8'h06, 0);
        c0 = wq_addr.size();
        sel(1); send(8'h07); send(8'h02); send(8'h00); send(8'h10); send(8'h55);
        chk(!so_oe, "R3 so_oe after 111 opcode", so_oe, 0);
        desel(1);
        chk(wq_addr.size() == c0 && commit_cnt == 0, "R3 no write after invalid", wq_addr.size() - c0, 0);
        rdsr({GUARD, 2'b10}, "R3 next select works", 0);
        one_op(8'h04, 0);

        // R7 writes with latch clear
        sel(0); send(8'h02); send(8'h00); send(8'h20); send(8'h11); desel(0);
        sel(0); send(8'h01); send(8'h3C); desel(0);
        chk(wq_addr.size() == c0 && commit_cnt == 0 && sr_cnt == 0, "R7 ignored writes",
            wq_addr.size() - c0 + commit_cnt + sr_cnt, 0);

        // R8 page write with wrap
        one_op(8'h06, 0);
        sel(0); send(8'h02); send(8'h01); send(8'h3E);
        send(8'hAA); send(8'hBB); send(8'hCC); desel(0);
        chk(wq_addr.size() == c0 + 3, "R8 byte pulses", wq_addr.size() - c0, 3);
        if (wq_addr.size() == c0 + 3) begin
            chk(wq_addr[c0] == 15'h013E && wq_data[c0] == 8'hAA, "R8 byte0", wq_addr[c0], 15'h013E);
            chk(wq_addr[c0+1] == 15'h013F && wq_data[c0+1] == 8'hBB, "R8 byte1", wq_addr[c0+1], 15'h013F);
            chk(wq_addr[c0+2] == 15'h0100 && wq_data[c0+2] == 8'hCC, "R8 page wrap", wq_addr[c0+2], 15'h0100);
        end
        chk(commit_cnt == 1, "R8 commit", commit_cnt, 1);
        rdsr({GUARD, 2'b00}, "R8 latch cleared", 0);

        // R9 status write
        one_op(8'h06, 1);
        sel(1); send(8'h09); send(8'h8C); desel(1);
        chk(sr_cnt == 1 && sr_last == 8'h8C, "R9 status write", sr_last, 8'h8C);
        rdsr({GUARD, 2'b00}, "R9 latch cleared", 0);

        // R10 busy
        wr_busy = 1'b1;
        one_op(8'h06, 0);
        rdsr({GUARD, 2'b01}, "R10 set latch ignored when busy", 0);
        sel(0); send(8'h03); send(8'h00); send(8'h00);
        xfer(8'h00, -1, r, o); chk(!o, "R10 read ignored when busy", o, 0);
        desel(0);
        wr_busy = 1'b0;

        // R11 pause mid byte
        rd(8'h03, 16'h0456, 3, 0, 4, "R11 read across pause");
        rd(8'h03, 16'h0777, 2, 1, 2, "R11 R12 pause mode3");

        // R2 activity while deselected
        for (int t = 0; t < 20; t++) begin
            sck = ~sck; si = t[1]; wait_clks(H);
        end
        sck = 1'b0; wait_clks(H);
        chk(!so_oe, "R2 toggles while deselected", so_oe, 0);
        rd(8'h03, 16'h0010, 1, 0, -1, "R2 next select clean");

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule